// File: doc/BRIEF.md
# Private Interrupt Configuration Register Bank

This block holds the per-core configuration and state for 32 private interrupts (IDs 0 to 31): group, enable, pending, active, priority, trigger mode, group modifier and a non-secure access-control word. It is reached over a single-cycle register bus. Each request carries an address, a byte/word size flag, write data, a write flag and a secure flag. Read data is registered and appears after the next rising clock edge.

When the global security-disable input is low, every non-secure access is filtered bit by bit through the group register. Interrupts whose group bit is 0 read as zero to a non-secure agent, and its writes to them have no effect. Non-secure agents also see priorities in a shifted view. The trigger mode is kept as one edge bit per interrupt and is presented on the bus as two-bit fields. The raw state vectors are driven out to a downstream prioritisation stage, which is not part of this block.

Top module: `irq_cfg_bank`

## Requirements
- R1: When `sec_dis` is 0 and `req_secure` is 0, the enable, pending, active and trigger-config accesses are masked by the group register. Masked bits read 0 and ignore writes. In every other case the mask is all ones.
- R2: Enable is at word 0x100 (set) and 0x180 (clear), pending at 0x200/0x280, active at 0x300/0x380. A write to the set address ORs the masked data into the state. A write to the clear address clears the masked bits. Both addresses read the same masked value.
- R3: A pending read returns the pending latch ORed with `line_level` for interrupts whose edge bit is 0. Writing the clear address does not hide a high level input.
- R4: Priorities occupy bytes 0x400 to 0x41F, one byte per ID (address 0x400+n). A word read at 0x400+4k returns ID 4k in bits 7:0 up to ID 4k+3 in bits 31:24. A word write updates those four IDs. A byte access uses bits 7:0 of the data.
- R5: For a non-secure access with `sec_dis`=0, a priority whose group bit is 1 reads as (stored<<1) truncated to 8 bits, and a write stores 0x80 | (data>>1). A priority whose group bit is 0 reads 0 and ignores the write.
- R6: Word 0xC00 reads the masked edge bits of IDs 0 to 15 at odd bit positions (ID n at bit 2n+1) and ignores writes. Word 0xC04 reads IDs 16 to 31 the same way (ID 16+n at bit 2n+1). A write to 0xC04 takes the odd bits as new edge bits for the masked IDs 16 to 31 only.
- R7: The group register is at word 0x080. With `sec_dis`=0, a non-secure access reads 0 and its write is ignored. Otherwise it reads and writes normally.
- R8: The group modifier (0xD00) and access control (0xE00) registers are accessible only by secure accesses with `sec_dis`=0. Any other access reads 0 and its write is ignored.
- R9: Unmapped offsets, word accesses with address bits 1:0 non-zero, and byte accesses outside the priority range return read data 0 and change no state.
- R10: The power register is at word 0x000. Only bit 0 (sleep request) is writable. Bit 1 (sleep done) always reads equal to bit 0, and `sleep_o` follows bit 0.
- R11: After reset all state is zero, except the group register, which takes the `GRP_RST` parameter value.
- R12: Read data appears on `rsp_rdata` in the cycle after the read request. It is 0 in the cycle after any write or any idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_dis | input | 1 | Global security-disable flag |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data (byte access uses bits 7:0) |
| req_secure | input | 1 | 1 = secure access |
| line_level | input | 32 | Live interrupt input levels |
| rsp_rdata | output | 32 | Registered read data |
| grp_o | output | 32 | Group bits |
| en_o | output | 32 | Enable bits |
| pend_o | output | 32 | Effective pending (latch or level input) |
| act_o | output | 32 | Active bits |
| trig_o | output | 32 | Edge-trigger bits |
| gmod_o | output | 32 | Group modifier bits |
| nsac_o | output | 32 | Non-secure access control word |
| prio_o | output | 256 | Priorities, ID n in bits 8n+7:8n |
| sleep_o | output | 1 | Sleep request state |

## Verification
The case hardest to reach from the ports is the combination of two masking layers in one access. The first layer is a non-secure word write to the priority or upper trigger register, where the group register allows only some lanes. The second is the shifted priority view applied inside those lanes. The bench first loads a group pattern that alternates between permitted and blocked IDs. It then sweeps every priority byte and word in both security states, so that each lane of each word meets both cases. The second config word is rewritten non-secure and read back in both views.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;

    localparam int NIRQ    = 32;
    localparam int PRIO_W  = 8;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / PRIO_W;
    localparam int ID_W    = $clog2(NIRQ);
    localparam int HALF    = NIRQ / 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PWR,
        SEL_GRP,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_AC_SET,
        SEL_AC_CLR,
        SEL_PRIO,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_GMOD,
        SEL_NSAC
    } reg_sel_e;

    typedef struct packed {
        logic [NIRQ-1:0]              grp;
        logic [NIRQ-1:0]              en;
        logic [NIRQ-1:0]              pend;
        logic [NIRQ-1:0]              act;
        logic [NIRQ-1:0]              trig;
        logic [NIRQ-1:0]              gmod;
        logic [DATA_W-1:0]            nsac;
        logic                         sleep;
        logic [NIRQ-1:0][PRIO_W-1:0]  prio;
        logic [DATA_W-1:0]            rdata;
    } bank_t;

    // one bit per interrupt -> bit 2n+1 of a 32-bit word
    function automatic logic [DATA_W-1:0] spread_odd(input logic [HALF-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < HALF; i++) r[2*i+1] = v[i];
        return r;
    endfunction

    // bit 2n+1 of a 32-bit word -> one bit per interrupt
    function automatic logic [HALF-1:0] gather_odd(input logic [DATA_W-1:0] v);
        logic [HALF-1:0] r;
        for (int i = 0; i < HALF; i++) r[i] = v[2*i+1];
        return r;
    endfunction

endpackage

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
    import irq_cfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              word_i,
    output reg_sel_e          sel_o,
    output logic [ID_W-1:0]   base_o
);

    localparam logic [ADDR_W-1:0] A_PWR    = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] A_GRP    = ADDR_W'(12'h080);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(12'h100);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(12'h180);
    localparam logic [ADDR_W-1:0] A_PD_SET = ADDR_W'(12'h200);
    localparam logic [ADDR_W-1:0] A_PD_CLR = ADDR_W'(12'h280);
    localparam logic [ADDR_W-1:0] A_AC_SET = ADDR_W'(12'h300);
    localparam logic [ADDR_W-1:0] A_AC_CLR = ADDR_W'(12'h380);
    localparam logic [ADDR_W-1:0] A_PRIO   = ADDR_W'(12'h400);
    localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(12'hC00);
    localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(12'hC04);
    localparam logic [ADDR_W-1:0] A_GMOD   = ADDR_W'(12'hD00);
    localparam logic [ADDR_W-1:0] A_NSAC   = ADDR_W'(12'hE00);

    localparam int PR_LSB = ID_W;   // priority window spans NIRQ bytes

    logic aligned;
    logic in_prio;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign in_prio = (addr_i[ADDR_W-1:PR_LSB] == A_PRIO[ADDR_W-1:PR_LSB]);

    always_comb begin
        sel_o = SEL_NONE;
        if (in_prio) begin
            if (!word_i || aligned) sel_o = SEL_PRIO;
        end else if (word_i && aligned) begin
            case (addr_i)
                A_PWR:    sel_o = SEL_PWR;
                A_GRP:    sel_o = SEL_GRP;
                A_EN_SET: sel_o = SEL_EN_SET;
                A_EN_CLR: sel_o = SEL_EN_CLR;
                A_PD_SET: sel_o = SEL_PD_SET;
                A_PD_CLR: sel_o = SEL_PD_CLR;
                A_AC_SET: sel_o = SEL_AC_SET;
                A_AC_CLR: sel_o = SEL_AC_CLR;
                A_CFG_LO: sel_o = SEL_CFG_LO;
                A_CFG_HI: sel_o = SEL_CFG_HI;
                A_GMOD:   sel_o = SEL_GMOD;
                A_NSAC:   sel_o = SEL_NSAC;
                default:  sel_o = SEL_NONE;
            endcase
        end
    end

    // first interrupt ID touched by a priority access
    assign base_o = word_i ? {addr_i[ID_W-1:2], 2'b00} : addr_i[ID_W-1:0];

endmodule

// File: rtl/irq_cfg_prio_lane.sv
module irq_cfg_prio_lane
    import irq_cfg_pkg::*;
(
    input  logic [PRIO_W-1:0] stored_i,
    input  logic [PRIO_W-1:0] wbyte_i,
    input  logic              permit_i,
    input  logic              ns_view_i,
    output logic [PRIO_W-1:0] rbyte_o,
    output logic [PRIO_W-1:0] nbyte_o,
    output logic              wr_ok_o
);

    always_comb begin
        if (!permit_i)      rbyte_o = '0;
        else if (ns_view_i) rbyte_o = {stored_i[PRIO_W-2:0], 1'b0};
        else                rbyte_o = stored_i;

        nbyte_o = ns_view_i ? {1'b1, wbyte_i[PRIO_W-1:1]} : wbyte_i;
        wr_ok_o = permit_i;
    end

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_cfg_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] GRP_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_dis,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_secure,
    input  logic [31:0]       line_level,
    output logic [31:0]       rsp_rdata,
    output logic [31:0]       grp_o,
    output logic [31:0]       en_o,
    output logic [31:0]       pend_o,
    output logic [31:0]       act_o,
    output logic [31:0]       trig_o,
    output logic [31:0]       gmod_o,
    output logic [31:0]       nsac_o,
    output logic [255:0]      prio_o,
    output logic              sleep_o
);

    localparam logic [NIRQ-1:0] UPPER = {{HALF{1'b1}}, {HALF{1'b0}}};

    bank_t st_d, st_q;

    reg_sel_e        sel;
    logic [ID_W-1:0] base_id;
    logic            rd_req;
    logic            wr_req;
    logic            ns_view;
    logic            sec_ok;
    logic [NIRQ-1:0] mask;
    logic [NIRQ-1:0] pend_eff;

    logic [LANES-1:0][ID_W-1:0]   lane_id;
    logic [LANES-1:0][PRIO_W-1:0] lane_rd;
    logic [LANES-1:0][PRIO_W-1:0] lane_nv;
    logic [LANES-1:0]             lane_ok;

    irq_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (req_addr),
        .word_i (req_word),
        .sel_o  (sel),
        .base_o (base_id)
    );

    assign rd_req   = req_valid && !req_write;
    assign wr_req   = req_valid &&  req_write;
    assign ns_view  = !req_secure && !sec_dis;
    assign sec_ok   =  req_secure && !sec_dis;
    assign mask     = ns_view ? st_q.grp : '1;
    assign pend_eff = st_q.pend | (line_level & ~st_q.trig);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_id[k] = base_id + ID_W'(k);

        irq_cfg_prio_lane u_lane (
            .stored_i  (st_q.prio[lane_id[k]]),
            .wbyte_i   (req_wdata[PRIO_W*k +: PRIO_W]),
            .permit_i  (ns_view ? st_q.grp[lane_id[k]] : 1'b1),
            .ns_view_i (ns_view),
            .rbyte_o   (lane_rd[k]),
            .nbyte_o   (lane_nv[k]),
            .wr_ok_o   (lane_ok[k])
        );
    end

    always_comb begin
        logic [NIRQ-1:0] upd;
        logic [NIRQ-1:0] rval;
        st_d       = st_q;
        st_d.rdata = '0;
        rval       = '0;
        upd        = '0;
        unique case (sel)
            SEL_PWR: begin
                rval = {30'b0, st_q.sleep, st_q.sleep};
                if (wr_req) st_d.sleep = req_wdata[0];
            end
            SEL_GRP: begin
                rval = ns_view ? '0 : st_q.grp;
                if (wr_req && !ns_view) st_d.grp = req_wdata;
            end
            SEL_EN_SET, SEL_EN_CLR: begin
                rval = st_q.en & mask;
                if (wr_req) st_d.en = (sel == SEL_EN_SET) ? (st_q.en | (req_wdata & mask))
                                                          : (st_q.en & ~(req_wdata & mask));
            end
            SEL_PD_SET, SEL_PD_CLR: begin
                rval = pend_eff & mask;
                if (wr_req) st_d.pend = (sel == SEL_PD_SET) ? (st_q.pend | (req_wdata & mask))
                                                            : (st_q.pend & ~(req_wdata & mask));
            end
            SEL_AC_SET, SEL_AC_CLR: begin
                rval = st_q.act & mask;
                if (wr_req) st_d.act = (sel == SEL_AC_SET) ? (st_q.act | (req_wdata & mask))
                                                           : (st_q.act & ~(req_wdata & mask));
            end
            SEL_PRIO: begin
                for (int k = 0; k < LANES; k++) begin
                    if (k == 0 || req_word) begin
                        rval = rval | (32'(lane_rd[k]) << (PRIO_W * k));
                        if (wr_req && lane_ok[k]) st_d.prio[lane_id[k]] = lane_nv[k];
                    end
                end
            end
            SEL_CFG_LO: begin
                rval = spread_odd(st_q.trig[HALF-1:0] & mask[HALF-1:0]);
            end
            SEL_CFG_HI: begin
                rval = spread_odd(st_q.trig[NIRQ-1:HALF] & mask[NIRQ-1:HALF]);
                upd  = mask & UPPER;
                if (wr_req) st_d.trig = (st_q.trig & ~upd)
                                      | ({gather_odd(req_wdata), {HALF{1'b0}}} & upd);
            end
            SEL_GMOD: begin
                rval = sec_ok ? st_q.gmod : '0;
                if (wr_req && sec_ok) st_d.gmod = req_wdata;
            end
            SEL_NSAC: begin
                rval = sec_ok ? st_q.nsac : '0;
                if (wr_req && sec_ok) st_d.nsac = req_wdata;
            end
            default: rval = '0;
        endcase
        if (rd_req) st_d.rdata = rval;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.grp <= GRP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_rdata = st_q.rdata;
    assign grp_o     = st_q.grp;
    assign en_o      = st_q.en;
    assign pend_o    = pend_eff;
    assign act_o     = st_q.act;
    assign trig_o    = st_q.trig;
    assign gmod_o    = st_q.gmod;
    assign nsac_o    = st_q.nsac;
    assign prio_o    = st_q.prio;
    assign sleep_o   = st_q.sleep;

    AST_NS_SET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_EN_SET && ns_view) |=> (((en_o ^ $past(en_o)) & ~$past(grp_o)) == '0)); // R1
    AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_EN_SET) |=> ((en_o & $past(en_o)) == $past(en_o))); // R2
    AST_GROUP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_GRP && ns_view) |=> $stable(grp_o)); // R7
    AST_SECURE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !sec_ok && (sel == SEL_GMOD || sel == SEL_NSAC)) |=> ($stable(gmod_o) && $stable(nsac_o))); // R8
    AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_NONE) |=> ($stable(en_o) && $stable(grp_o) && $stable(trig_o)
                                         && $stable(prio_o) && $stable(act_o) && $stable(sleep_o))); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (rsp_rdata == '0)); // R12

endmodule

// File: tb/sim_irq_cfg_bank.sv
module sim_irq_cfg_bank;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sec_dis = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic         req_word = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_secure = 1'b0;
    logic [31:0]  line_level = '0;
    logic [31:0]  rsp_rdata;
    logic [31:0]  grp_o, en_o, pend_o, act_o, trig_o, gmod_o, nsac_o;
    logic [255:0] prio_o;
    logic         sleep_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    logic [7:0] prio_m [32];
    localparam logic [31:0] G = 32'hAAAA_5555;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cfg_bank u0 (
        .clk, .rst_n, .sec_dis, .req_valid, .req_write, .req_word, .req_addr,
        .req_wdata, .req_secure, .line_level, .rsp_rdata, .grp_o, .en_o,
        .pend_o, .act_o, .trig_o, .gmod_o, .nsac_o, .prio_o, .sleep_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit w, input bit word, input logic [11:0] a,
                        input logic [31:0] d, input bit s, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_word = word;
        req_addr = a; req_wdata = d; req_secure = s;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        r = rsp_rdata;
    endtask

    task automatic wr(input bit word, input logic [11:0] a, input logic [31:0] d, input bit s);
        logic [31:0] r;
        xfer(1'b1, word, a, d, s, r);
        chk("R12 write returns zero", r, 32'h0);
    endtask

    task automatic rdchk(input string tag, input bit word, input logic [11:0] a,
                         input bit s, input logic [31:0] exp);
        logic [31:0] r;
        xfer(1'b0, word, a, 32'h0, s, r);
        chk(tag, r, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rdchk("R11 group reset", 1, 12'h080, 1, 32'h0);
        rdchk("R11 enable reset", 1, 12'h100, 1, 32'h0);
        rdchk("R11 prio reset", 1, 12'h41C, 1, 32'h0);
        rdchk("R11 power reset", 1, 12'h000, 1, 32'h0);
        chk("R11 prio out", prio_o[31:0], 32'h0);

        // R7 group access
        wr(1, 12'h080, G, 1);
        rdchk("R7 secure group", 1, 12'h080, 1, G);
        wr(1, 12'h080, 32'h0, 0);
        rdchk("R7 ns write ignored", 1, 12'h080, 1, G);
        rdchk("R7 ns read zero", 1, 12'h080, 0, 32'h0);

        // R1 / R2 enable
        wr(1, 12'h100, 32'hFFFF_FFFF, 0);
        rdchk("R1 ns set masked", 1, 12'h100, 1, G);
        wr(1, 12'h100, 32'hFFFF_FFFF, 1);
        wr(1, 12'h180, 32'hFFFF_FFFF, 0);
        rdchk("R1 ns clear masked", 1, 12'h180, 1, ~G);
        wr(1, 12'h180, 32'hFFFF_FFFF, 1);
        wr(1, 12'h100, 32'hF0F0_F0F0, 1);
        wr(1, 12'h180, 32'h3000_0003, 1);
        rdchk("R2 set addr read", 1, 12'h100, 1, 32'hC0F0_F0F0);
        rdchk("R2 clear addr read", 1, 12'h180, 1, 32'hC0F0_F0F0);
        rdchk("R1 ns masked read", 1, 12'h100, 0, 32'h80A0_5050);
        wr(1, 12'h300, 32'h0000_FFFF, 1);
        wr(1, 12'h380, 32'h0000_00FF, 1);
        rdchk("R2 active pair", 1, 12'h380, 1, 32'h0000_FF00);

        // R3 pending
        line_level = 32'h0000_FFFF;
        wr(1, 12'h200, 32'h0001_0000, 1);
        rdchk("R3 latch or level", 1, 12'h200, 1, 32'h0001_FFFF);
        rdchk("R1 ns pending masked", 1, 12'h280, 0, 32'h0000_5555);
        wr(1, 12'h280, 32'h0000_FFFF, 1);
        rdchk("R3 level survives clear", 1, 12'h200, 1, 32'h0001_FFFF);
        line_level = 32'h0;
        rdchk("R3 latch only", 1, 12'h200, 1, 32'h0001_0000);
        wr(1, 12'h280, 32'h0001_0000, 1);
        rdchk("R2 pending cleared", 1, 12'h200, 1, 32'h0);

        // R6 trigger configuration
        wr(1, 12'hC04, 32'hAAAA_AAAA, 1);
        rdchk("R6 cfg hi readback", 1, 12'hC04, 1, 32'hAAAA_AAAA);
        wr(1, 12'hC00, 32'hFFFF_FFFF, 1);
        rdchk("R6 cfg lo ignores write", 1, 12'hC00, 1, 32'h0);
        chk("R6 trig out", trig_o, 32'hFFFF_0000);
        line_level = 32'hFFFF_0000;
        rdchk("R3 edge not level", 1, 12'h200, 1, 32'h0);
        wr(1, 12'hC04, 32'h0, 0);
        rdchk("R6 ns masked write", 1, 12'hC04, 1, 32'h2222_2222);
        rdchk("R6 ns masked read", 1, 12'hC04, 0, 32'h0);
        rdchk("R3 mixed triggers", 1, 12'h200, 1, 32'hAAAA_0000);
        line_level = 32'h0;

        // R4 priority layout, secure
        for (int i = 0; i < 32; i++) prio_m[i] = 8'((i * 7 + 3) & 8'hFF);
        for (int w = 0; w < 8; w++)
            wr(1, 12'h400 + 12'(4*w), {prio_m[4*w+3], prio_m[4*w+2], prio_m[4*w+1], prio_m[4*w]}, 1);
        for (int i = 0; i < 32; i++)
            rdchk("R4 byte read", 0, 12'h400 + 12'(i), 1, {24'h0, prio_m[i]});
        for (int w = 0; w < 8; w++)
            rdchk("R4 word read", 1, 12'h400 + 12'(4*w), 1,
                  {prio_m[4*w+3], prio_m[4*w+2], prio_m[4*w+1], prio_m[4*w]});
        chk("R4 prio out", prio_o[63:32], {prio_m[7], prio_m[6], prio_m[5], prio_m[4]});

        // R5 non-secure priority view
        for (int i = 0; i < 32; i++) begin
            logic [7:0] v;
            v = 8'((i * 13 + 1) & 8'hFF);
            wr(0, 12'h400 + 12'(i), {24'h0, v}, 0);
            if (G[i]) prio_m[i] = 8'h80 | (v >> 1);
        end
        for (int i = 0; i < 32; i++) begin
            rdchk("R5 ns byte read", 0, 12'h400 + 12'(i), 0,
                  G[i] ? {24'h0, prio_m[i][6:0], 1'b0} : 32'h0);
            rdchk("R5 secure after ns write", 0, 12'h400 + 12'(i), 1, {24'h0, prio_m[i]});
        end
        wr(1, 12'h400, 32'h1122_3344, 0);
        for (int k = 0; k < 4; k++)
            if (G[k]) prio_m[k] = 8'h80 | (8'(32'h1122_3344 >> (8*k)) >> 1);
        e = '0;
        for (int k = 0; k < 4; k++)
            if (G[k]) e = e | (32'({prio_m[k][6:0], 1'b0}) << (8*k));
        rdchk("R5 ns word lanes", 1, 12'h400, 0, e);
        rdchk("R4 secure word after ns", 1, 12'h400, 1,
              {prio_m[3], prio_m[2], prio_m[1], prio_m[0]});
        sec_dis = 1'b1;
        wr(0, 12'h401, 32'h42, 0);
        rdchk("R1 sec_dis full access", 0, 12'h401, 0, 32'h42);
        sec_dis = 1'b0;

        // R8 group modifier and access control
        wr(1, 12'hD00, 32'h0000_1234, 1);
        wr(1, 12'hE00, 32'hCAFE_0001, 1);
        rdchk("R8 gmod secure", 1, 12'hD00, 1, 32'h0000_1234);
        rdchk("R8 nsac secure", 1, 12'hE00, 1, 32'hCAFE_0001);
        wr(1, 12'hD00, 32'h0, 0);
        wr(1, 12'hE00, 32'h0, 0);
        rdchk("R8 gmod ns write ignored", 1, 12'hD00, 1, 32'h0000_1234);
        rdchk("R8 nsac ns read zero", 1, 12'hE00, 0, 32'h0);
        sec_dis = 1'b1;
        rdchk("R8 gmod read zero when disabled", 1, 12'hD00, 1, 32'h0);
        wr(1, 12'hE00, 32'hFFFF_FFFF, 1);
        sec_dis = 1'b0;
        rdchk("R8 nsac write ignored when disabled", 1, 12'hE00, 1, 32'hCAFE_0001);

        // R9 unmapped and unsupported
        wr(1, 12'h7F0, 32'hFFFF_FFFF, 1);
        rdchk("R9 unmapped read", 1, 12'h7F0, 1, 32'h0);
        rdchk("R9 byte read of word reg", 0, 12'h080, 1, 32'h0);
        wr(0, 12'h100, 32'hFF, 1);
        rdchk("R9 byte write dropped", 1, 12'h100, 1, 32'hC0F0_F0F0);
        rdchk("R9 misaligned word", 1, 12'h402, 1, 32'h0);

        // R10 power register
        wr(1, 12'h000, 32'h1, 0);
        rdchk("R10 sleep set", 1, 12'h000, 1, 32'h3);
        chk("R10 sleep out", {31'h0, sleep_o}, 32'h1);
        wr(1, 12'h000, 32'hFFFF_FFFE, 1);
        rdchk("R10 only bit0 writable", 1, 12'h000, 1, 32'h0);
        wr(1, 12'h000, 32'h0000_FFFF, 1);
        rdchk("R10 mirror", 1, 12'h000, 1, 32'h3);

        // R7 with security disabled
        sec_dis = 1'b1;
        wr(1, 12'h080, 32'h0000_000F, 0);
        rdchk("R7 ns access when disabled", 1, 12'h080, 0, 32'h0000_000F);
        sec_dis = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule